// File: doc/BRIEF.md
# CPU Clock Frequency-Change Sequencer

This block moves a CPU clock domain from one of five performance levels to another. It takes an old level index, a new level index and a start strobe. It then drives a register model of the clock unit through single-cycle write strobes, and it watches that unit's status inputs. The sequence covers two divider registers, the PLL configuration word, a lock-time register and the core clock mux. The mux can park the core on a fixed safe PLL while the main PLL relocks.

The per-level PLL settings and divider words are held in internal tables. The block chooses between two PLL paths. If the M and P values are the same for both levels, it rewrites only the post-divider S. Otherwise it runs a full relock, with the core parked on the safe PLL for the duration. The order of the divider and PLL steps depends on the direction of the change. When the levels are equal or an index is out of range, no writes are made. Any wait that exceeds a configurable cycle limit aborts the sequence and raises an error flag.

Top module: `clk_step_seq`

## Requirements
- R1: There are five levels, 0 to 4, and a lower index means a faster clock. PLL words are packed as M in bits 25:16, P in bits 13:8 and S in bits 2:0. The M/P/S values for levels 0 to 4 are 150/3/1, 250/6/1, 200/6/1, 250/6/2 and 200/6/3.
- R2: When old and new levels have equal M and P, the only PLL action is a single write of {pll_rdata_i[31:3], new S}, with no mux or lock-time activity.
- R3: When M or P differ, the PLL write takes pll_rdata_i with bits 25:16, 13:8 and 2:0 cleared, then ORs in the new level word.
- R4: When moving to a faster level, both divider writes come first and the PLL change follows.
- R5: When moving to a slower level, the PLL change comes first and both divider writes follow.
- R6: A relock runs in this order: mux write with mux_safe_o=1; wait for mux_stat_i==2; lock-time write; PLL write; wait for pll_locked_i; mux write with mux_safe_o=0; wait for mux_stat_i==1.
- R7: After the first divider write, the block waits until div0_stat_i & 0x01111111 is zero. After the second, it waits until div1_stat_i & 0x11 is zero. Other status bits are ignored.
- R8: The first divider word carries seven 3-bit fields at bit offsets 0,4,...,24. In that order they are core, mem0, mem1, periph, trace, dbg and pllout. Their values are 0,3,7,3,4,1,7 for levels 0-1; 0,3,7,3,3,1,7 for levels 2-3; and 0,1,3,1,3,1,0 for level 4. All other bits are zero. The second divider write puts hi in bits 6:4 and lo in bits 2:0, with hi/lo values 5/2, 4/2, 3/1, 3/1 and 3/0 for levels 0 to 4. The remaining bits are taken from div1_rdata_i.
- R9: With equal old and new indices, no writes are made and done_o is high in the cycle after the start strobe.
- R10: busy_o is high from the cycle after an accepted start through the done cycle. A start strobe while busy_o is high is ignored.
- R11: A wait that lasts TIMEOUT cycles aborts the sequence with done_o and sets err_o. err_o holds until the next accepted start clears it.
- R12: An index above 4 sets err_o, makes no writes, and gives done_o in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| old_lvl_i | input | 3 | Current level index |
| new_lvl_i | input | 3 | Target level index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or bad index on last request |
| div0_we_o | output | 1 | First divider register write strobe |
| div0_wdata_o | output | 32 | First divider register data |
| div0_stat_i | input | 32 | First divider busy status |
| div1_we_o | output | 1 | Second divider register write strobe |
| div1_wdata_o | output | 32 | Second divider register data |
| div1_rdata_i | input | 32 | Second divider register current value |
| div1_stat_i | input | 8 | Second divider busy status |
| mux_we_o | output | 1 | Core mux select write strobe |
| mux_safe_o | output | 1 | Mux select value: 1 safe PLL, 0 main PLL |
| mux_stat_i | input | 3 | Mux status: 1 main, 2 safe, other values in transit |
| lock_we_o | output | 1 | Lock-time register write strobe |
| lock_time_o | output | LOCK_W | Lock-time value |
| pll_we_o | output | 1 | PLL configuration write strobe |
| pll_wdata_o | output | 32 | PLL configuration data |
| pll_rdata_i | input | 32 | PLL configuration current value |
| pll_locked_i | input | 1 | PLL lock indication |

## Verification
The assertions assume the register model behaves causally. A mux status of 2 is taken to mean the core is already parked. A busy status seen in the cycle after a divider write is taken to belong to that write. Lock may drop no earlier than the cycle after the PLL write. The bench model is built to meet these assumptions. Each write strobe starts a latency counter at the next edge, the mux reports an in-transit code 4 until the switch completes, and bits outside the busy masks are held high throughout. Level changes are chained so that the model always starts from the old level's state.

// File: rtl/clk_step_pkg.sv
package clk_step_pkg;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned NUM_LVL = 5;
  localparam int unsigned DIV0_FLDS = 7;
  localparam int unsigned FLD_W = 3;
  localparam logic [31:0] PLL_MPS_MASK = 32'h03FF_3F07;
  localparam logic [31:0] PLL_MP_MASK = 32'h03FF_3F00;
  localparam logic [31:0] DIV0_BUSY_MASK = 32'h0111_1111;
  localparam logic [7:0] DIV1_BUSY_MASK = 8'h11;
  localparam logic [31:0] DIV1_FLD_MASK = 32'h0000_0077;
  localparam logic [2:0] MUX_ST_MAIN = 3'd1;
  localparam logic [2:0] MUX_ST_SAFE = 3'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIV0_WR, ST_DIV0_WT, ST_DIV1_WR, ST_DIV1_WT, ST_S_WR,
    ST_PARK, ST_PARK_WT, ST_LOCK_WR, ST_PLL_WR, ST_LOCK_WT,
    ST_BACK, ST_BACK_WT, ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
  } pll_cfg_t;

  function automatic pll_cfg_t lvl_pll(input logic [LVL_W-1:0] l);
    case (l)
      3'd0:    return '{m: 10'd150, p: 6'd3, s: 3'd1};
      3'd1:    return '{m: 10'd250, p: 6'd6, s: 3'd1};
      3'd2:    return '{m: 10'd200, p: 6'd6, s: 3'd1};
      3'd3:    return '{m: 10'd250, p: 6'd6, s: 3'd2};
      default: return '{m: 10'd200, p: 6'd6, s: 3'd3};
    endcase
  endfunction

  function automatic logic [31:0] pll_word(input pll_cfg_t c);
    return {6'd0, c.m, 2'd0, c.p, 5'd0, c.s};
  endfunction

  // field 0 in the low bits: core, mem0, mem1, periph, trace, dbg, pllout
  function automatic logic [DIV0_FLDS*FLD_W-1:0] lvl_div0(input logic [LVL_W-1:0] l);
    case (l)
      3'd0, 3'd1: return {3'd7, 3'd1, 3'd4, 3'd3, 3'd7, 3'd3, 3'd0};
      3'd2, 3'd3: return {3'd7, 3'd1, 3'd3, 3'd3, 3'd7, 3'd3, 3'd0};
      default:    return {3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0};
    endcase
  endfunction

  // {hi, lo}
  function automatic logic [2*FLD_W-1:0] lvl_div1(input logic [LVL_W-1:0] l);
    case (l)
      3'd0:       return {3'd5, 3'd2};
      3'd1:       return {3'd4, 3'd2};
      3'd2, 3'd3: return {3'd3, 3'd1};
      default:    return {3'd3, 3'd0};
    endcase
  endfunction
endpackage

// File: rtl/clk_step_lut.sv
module clk_step_lut
  import clk_step_pkg::*;
(
  input  logic [LVL_W-1:0]   old_lvl_i,
  input  logic [LVL_W-1:0]   new_lvl_i,
  output logic [31:0]        pll_word_o,
  output logic [31:0]        div0_word_o,
  output logic [2*FLD_W-1:0] div1_fld_o,
  output logic               faster_o,
  output logic               same_o,
  output logic               relock_o,
  output logic               bad_o
);
  logic [31:0] old_word;
  logic [DIV0_FLDS*FLD_W-1:0] div0_flds;

  assign old_word   = pll_word(lvl_pll(old_lvl_i));
  assign pll_word_o = pll_word(lvl_pll(new_lvl_i));
  assign div0_flds  = lvl_div0(new_lvl_i);
  assign div1_fld_o = lvl_div1(new_lvl_i);

  for (genvar k = 0; k < DIV0_FLDS; k++) begin : g_div0
    assign div0_word_o[4*k +: 4] = {1'b0, div0_flds[FLD_W*k +: FLD_W]};
  end
  assign div0_word_o[31:4*DIV0_FLDS] = '0;

  assign faster_o = new_lvl_i < old_lvl_i;
  assign same_o   = new_lvl_i == old_lvl_i;
  assign relock_o = |((old_word ^ pll_word_o) & PLL_MP_MASK);
  assign bad_o    = (old_lvl_i >= LVL_W'(NUM_LVL)) || (new_lvl_i >= LVL_W'(NUM_LVL));
endmodule

// File: rtl/clk_step_timer.sv
module clk_step_timer #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_step_fsm.sv
module clk_step_fsm
  import clk_step_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    bad_i,
  input  logic    same_i,
  input  logic    faster_i,
  input  logic    relock_i,
  input  logic    div0_clr_i,
  input  logic    div1_clr_i,
  input  logic    parked_i,
  input  logic    on_main_i,
  input  logic    locked_i,
  input  logic    expired_i,
  output seq_st_e st_o,
  output logic    wait_o,
  output logic    abort_o
);
  seq_st_e st_q, st_d;
  seq_st_e pll_entry;

  assign pll_entry = relock_i ? ST_PARK : ST_S_WR;

  always_comb begin
    st_d    = st_q;
    abort_o = 1'b0;
    unique case (st_q)
      ST_IDLE:
        if (start_i) begin
          if (bad_i || same_i) st_d = ST_DONE;
          else if (faster_i)   st_d = ST_DIV0_WR;
          else                 st_d = pll_entry;
        end
      ST_DIV0_WR: st_d = ST_DIV0_WT;
      ST_DIV0_WT:
        if (div0_clr_i)     st_d = ST_DIV1_WR;
        else if (expired_i) begin st_d = ST_DONE; abort_o = 1'b1; end
      ST_DIV1_WR: st_d = ST_DIV1_WT;
      ST_DIV1_WT:
        if (div1_clr_i)     st_d = faster_i ? pll_entry : ST_DONE;
        else if (expired_i) begin st_d = ST_DONE; abort_o = 1'b1; end
      ST_S_WR:    st_d = faster_i ? ST_DONE : ST_DIV0_WR;
      ST_PARK:    st_d = ST_PARK_WT;
      ST_PARK_WT:
        if (parked_i)       st_d = ST_LOCK_WR;
        else if (expired_i) begin st_d = ST_DONE; abort_o = 1'b1; end
      ST_LOCK_WR: st_d = ST_PLL_WR;
      ST_PLL_WR:  st_d = ST_LOCK_WT;
      ST_LOCK_WT:
        if (locked_i)       st_d = ST_BACK;
        else if (expired_i) begin st_d = ST_DONE; abort_o = 1'b1; end
      ST_BACK:    st_d = ST_BACK_WT;
      ST_BACK_WT:
        if (on_main_i)      st_d = faster_i ? ST_DONE : ST_DIV0_WR;
        else if (expired_i) begin st_d = ST_DONE; abort_o = 1'b1; end
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o   = st_q;
  assign wait_o = (st_q == ST_DIV0_WT) || (st_q == ST_DIV1_WT) || (st_q == ST_PARK_WT) ||
                  (st_q == ST_LOCK_WT) || (st_q == ST_BACK_WT);
endmodule

// File: rtl/clk_step_seq.sv
module clk_step_seq
  import clk_step_pkg::*;
#(
  parameter int unsigned TIMEOUT   = 64,
  parameter int unsigned LOCK_W    = 16,
  parameter int unsigned LOCK_TIME = 270
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        old_lvl_i,
  input  logic [2:0]        new_lvl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              div0_we_o,
  output logic [31:0]       div0_wdata_o,
  input  logic [31:0]       div0_stat_i,
  output logic              div1_we_o,
  output logic [31:0]       div1_wdata_o,
  input  logic [31:0]       div1_rdata_i,
  input  logic [7:0]        div1_stat_i,
  output logic              mux_we_o,
  output logic              mux_safe_o,
  input  logic [2:0]        mux_stat_i,
  output logic              lock_we_o,
  output logic [LOCK_W-1:0] lock_time_o,
  output logic              pll_we_o,
  output logic [31:0]       pll_wdata_o,
  input  logic [31:0]       pll_rdata_i,
  input  logic              pll_locked_i
);
  seq_st_e st;
  logic idle, accept, wait_act, expired, abort;
  logic [LVL_W-1:0] old_q, new_q, old_sel, new_sel;
  logic err_q;
  logic [31:0] pll_word, div0_word;
  logic [2*FLD_W-1:0] div1_fld;
  logic faster, same, relock, bad;

  assign idle   = st == ST_IDLE;
  assign accept = idle && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
      new_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      old_q <= old_lvl_i;
      new_q <= new_lvl_i;
      err_q <= bad;
    end else if (abort) begin
      err_q <= 1'b1;
    end
  end

  // decisions taken from the inputs at start, from the held levels afterwards
  assign old_sel = idle ? old_lvl_i : old_q;
  assign new_sel = idle ? new_lvl_i : new_q;

  clk_step_lut u_lut (
    .old_lvl_i  (old_sel),
    .new_lvl_i  (new_sel),
    .pll_word_o (pll_word),
    .div0_word_o(div0_word),
    .div1_fld_o (div1_fld),
    .faster_o   (faster),
    .same_o     (same),
    .relock_o   (relock),
    .bad_o      (bad)
  );

  clk_step_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wait_act),
    .expired_o(expired)
  );

  clk_step_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bad_i     (bad),
    .same_i    (same),
    .faster_i  (faster),
    .relock_i  (relock),
    .div0_clr_i((div0_stat_i & DIV0_BUSY_MASK) == '0),
    .div1_clr_i((div1_stat_i & DIV1_BUSY_MASK) == '0),
    .parked_i  (mux_stat_i == MUX_ST_SAFE),
    .on_main_i (mux_stat_i == MUX_ST_MAIN),
    .locked_i  (pll_locked_i),
    .expired_i (expired),
    .st_o      (st),
    .wait_o    (wait_act),
    .abort_o   (abort)
  );

  assign busy_o = !idle;
  assign done_o = st == ST_DONE;
  assign err_o  = err_q;

  assign div0_we_o    = st == ST_DIV0_WR;
  assign div0_wdata_o = div0_word;
  assign div1_we_o    = st == ST_DIV1_WR;
  assign div1_wdata_o = (div1_rdata_i & ~DIV1_FLD_MASK) |
                        {25'd0, div1_fld[2*FLD_W-1 -: FLD_W], 1'b0, div1_fld[FLD_W-1:0]};

  assign mux_we_o   = (st == ST_PARK) || (st == ST_BACK);
  assign mux_safe_o = st == ST_PARK;

  assign lock_we_o   = st == ST_LOCK_WR;
  assign lock_time_o = LOCK_W'(LOCK_TIME);

  assign pll_we_o    = (st == ST_S_WR) || (st == ST_PLL_WR);
  assign pll_wdata_o = (st == ST_S_WR) ? {pll_rdata_i[31:3], pll_word[2:0]}
                                       : ((pll_rdata_i & ~PLL_MPS_MASK) | pll_word);
endmodule

// File: rtl/clk_step_chk.sv
module clk_step_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        div0_we_o,
  input logic        div1_we_o,
  input logic        mux_we_o,
  input logic        lock_we_o,
  input logic        pll_we_o,
  input logic [31:0] div0_stat_i,
  input logic [2:0]  mux_stat_i
);
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({div0_we_o, div1_we_o, mux_we_o, lock_we_o, pll_we_o})); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_LOCK_THEN_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_we_o |=> pll_we_o); // R6
  AST_PARKED_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_we_o |-> $past(mux_stat_i) == 3'd2); // R6
  AST_DIV0_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div1_we_o |-> ($past(div0_stat_i) & 32'h0111_1111) == 32'd0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(div0_we_o || div1_we_o || mux_we_o || lock_we_o || pll_we_o)); // R10
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
endmodule

bind clk_step_seq clk_step_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div0_we_o  (div0_we_o),
  .div1_we_o  (div1_we_o),
  .mux_we_o   (mux_we_o),
  .lock_we_o  (lock_we_o),
  .pll_we_o   (pll_we_o),
  .div0_stat_i(div0_stat_i),
  .mux_stat_i (mux_stat_i)
);

// File: tb/tb_clk_step_seq.sv
module tb_clk_step_seq;
  localparam int TIMEOUT = 32;
  localparam logic [31:0] PLL_JUNK = 32'h8000_4040;
  localparam logic [31:0] DIV1_INIT = 32'h5A5A_5A08;

  // {old, new, event count, events (first in low digit)}; events:
  // 1 div0, 2 div1, 3 S-only pll, 4 park, 5 lock time, 6 full pll, 7 back to main
  localparam logic [33:0] VEC [9] = '{
    {3'd4, 3'd2, 4'd3, 24'o00000321},
    {3'd2, 3'd0, 4'd6, 24'o00765421},
    {3'd0, 3'd1, 4'd6, 24'o00217654},
    {3'd1, 3'd3, 4'd3, 24'o00000213},
    {3'd3, 3'd3, 4'd0, 24'o00000000},
    {3'd3, 3'd1, 4'd3, 24'o00000321},
    {3'd1, 3'd4, 4'd6, 24'o00217654},
    {3'd4, 3'd0, 4'd6, 24'o00765421},
    {3'd0, 3'd4, 4'd6, 24'o00217654}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] old_lvl = '0, new_lvl = '0;
  logic busy, done, err;
  logic div0_we, div1_we, mux_we, mux_safe, lock_we, pll_we, pll_locked;
  logic [31:0] div0_wdata, div1_wdata, pll_wdata, div0_stat, div1_rdata, pll_rdata;
  logic [7:0] div1_stat;
  logic [2:0] mux_stat;
  logic [15:0] lock_time;

  int n_chk = 0, n_err = 0, cyc_n = 0;
  int ev [16];
  int ev_t [16];
  int ev_n = 0;
  bit parked = 0, stuck = 0;

  always #5 clk = ~clk;

  clk_step_seq #(.TIMEOUT(TIMEOUT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .old_lvl_i(old_lvl), .new_lvl_i(new_lvl),
    .busy_o(busy), .done_o(done), .err_o(err),
    .div0_we_o(div0_we), .div0_wdata_o(div0_wdata), .div0_stat_i(div0_stat),
    .div1_we_o(div1_we), .div1_wdata_o(div1_wdata), .div1_rdata_i(div1_rdata), .div1_stat_i(div1_stat),
    .mux_we_o(mux_we), .mux_safe_o(mux_safe), .mux_stat_i(mux_stat),
    .lock_we_o(lock_we), .lock_time_o(lock_time),
    .pll_we_o(pll_we), .pll_wdata_o(pll_wdata), .pll_rdata_i(pll_rdata), .pll_locked_i(pll_locked)
  );

  function automatic logic [31:0] bpll(input logic [2:0] l);
    case (l)
      3'd0:    return {6'd0, 10'd150, 2'd0, 6'd3, 5'd0, 3'd1};
      3'd1:    return {6'd0, 10'd250, 2'd0, 6'd6, 5'd0, 3'd1};
      3'd2:    return {6'd0, 10'd200, 2'd0, 6'd6, 5'd0, 3'd1};
      3'd3:    return {6'd0, 10'd250, 2'd0, 6'd6, 5'd0, 3'd2};
      default: return {6'd0, 10'd200, 2'd0, 6'd6, 5'd0, 3'd3};
    endcase
  endfunction

  function automatic logic [31:0] bdiv0(input logic [2:0] l);
    case (l)
      3'd0, 3'd1: return 32'h0714_3730;
      3'd2, 3'd3: return 32'h0713_3730;
      default:    return 32'h0013_1310;
    endcase
  endfunction

  function automatic logic [31:0] bdiv1(input logic [2:0] l);
    logic [2:0] hi, lo;
    case (l)
      3'd0:       begin hi = 3'd5; lo = 3'd2; end
      3'd1:       begin hi = 3'd4; lo = 3'd2; end
      3'd2, 3'd3: begin hi = 3'd3; lo = 3'd1; end
      default:    begin hi = 3'd3; lo = 3'd0; end
    endcase
    return (DIV1_INIT & ~32'h77) | {25'd0, hi, 1'b0, lo};
  endfunction

  // clock unit register model
  logic [31:0] div0_q, div1_q, pll_q;
  int d0_cnt, d1_cnt, m_cnt, lk_cnt;
  bit m_safe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div0_q <= '0; div1_q <= DIV1_INIT; pll_q <= PLL_JUNK | bpll(3'd4);
      d0_cnt <= 0; d1_cnt <= 0; m_cnt <= 0; lk_cnt <= 0; m_safe <= 0;
    end else begin
      cyc_n <= cyc_n + 1;
      if (div0_we) begin div0_q <= div0_wdata; d0_cnt <= 3; end
      else if (d0_cnt != 0) d0_cnt <= d0_cnt - 1;
      if (div1_we) begin div1_q <= div1_wdata; d1_cnt <= 2; end
      else if (d1_cnt != 0) d1_cnt <= d1_cnt - 1;
      if (mux_we) begin m_safe <= mux_safe; m_cnt <= 4; end
      else if (m_cnt != 0) m_cnt <= m_cnt - 1;
      if (pll_we) begin pll_q <= pll_wdata; lk_cnt <= 5; end
      else if (lk_cnt != 0) lk_cnt <= lk_cnt - 1;
    end
  end

  assign div0_stat  = ((d0_cnt != 0) ? 32'h0111_1111 : 32'h0) | 32'h8888_8888;
  assign div1_stat  = ((d1_cnt != 0) ? 8'h11 : 8'h00) | 8'hCC;
  assign mux_stat   = (m_cnt != 0) ? 3'd4 : (m_safe ? 3'd2 : 3'd1);
  assign div1_rdata = div1_q;
  assign pll_rdata  = pll_q;
  assign pll_locked = (lk_cnt == 0) && !stuck;

  always @(negedge clk) begin
    if (rst_n) begin
      int code;
      code = 0;
      if (div0_we)                code = 1;
      else if (div1_we)           code = 2;
      else if (pll_we && !parked) code = 3;
      else if (mux_we && mux_safe) begin code = 4; parked = 1; end
      else if (lock_we)           code = 5;
      else if (pll_we)            code = 6;
      else if (mux_we)            begin code = 7; parked = 0; end
      if (code != 0) begin
        if (ev_n < 16) begin ev[ev_n] = code; ev_t[ev_n] = cyc_n; end
        ev_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [2:0] n, input bit poke, output int cyc);
    ev_n = 0;
    @(negedge clk);
    old_lvl = o; new_lvl = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
    while (!done && cyc < 2000) begin
      if (poke && cyc == 3) begin start = 1'b1; old_lvl = 3'd1; new_lvl = 3'd2; end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(done == 1'b1, "R10 done reached", 32'(done), 32'd1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic chk_seq(input logic [3:0] ne, input logic [23:0] seq, input string tag);
    chk(ev_n == int'(ne), {tag, " event count"}, 32'(ev_n), 32'(ne));
    for (int k = 0; k < int'(ne) && k < ev_n; k++)
      chk(ev[k] == int'(seq[3*k +: 3]), {tag, " event order"}, 32'(ev[k]), 32'(seq[3*k +: 3]));
    for (int k = 0; k + 1 < ev_n && k < 15; k++)
      if (ev[k] == 1 && ev[k+1] == 2)
        chk(ev_t[k+1] - ev_t[k] == 5, "R7 div0 busy wait", 32'(ev_t[k+1] - ev_t[k]), 32'd5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err} == 3'b000, "R10 reset state", {29'd0, busy, done, err}, 32'd0);
    chk({div0_we, div1_we, mux_we, lock_we, pll_we} == 5'd0, "R10 reset strobes",
        {27'd0, div0_we, div1_we, mux_we, lock_we, pll_we}, 32'd0);

    for (int i = 0; i < 9; i++) begin
      logic [2:0] o, n;
      string tag;
      o = VEC[i][33:31];
      n = VEC[i][30:28];
      tag = (n < o) ? "R4,R6" : (n > o) ? "R5,R6" : "R9";
      run(o, n, 1'b0, cyc);
      chk_seq(VEC[i][27:24], VEC[i][23:0], tag);
      if (o == n) chk(cyc == 1, "R9 done next cycle", 32'(cyc), 32'd1);
      chk(pll_q == (PLL_JUNK | bpll(n)), "R1,R2,R3 pll word", pll_q, PLL_JUNK | bpll(n));
      chk(div0_q == bdiv0(n), "R8 div0 word", div0_q, bdiv0(n));
      chk(div1_q == bdiv1(n), "R8 div1 word", div1_q, bdiv1(n));
      chk(err == 1'b0, "R7,R11 no error", 32'(err), 32'd0);
    end

    // start while busy is ignored
    run(3'd4, 3'd1, 1'b1, cyc);
    chk_seq(4'd6, 24'o00765421, "R10 poke");
    chk(pll_q == (PLL_JUNK | bpll(3'd1)), "R10 pll after poke", pll_q, PLL_JUNK | bpll(3'd1));
    chk(div1_q == bdiv1(3'd1), "R10 div1 after poke", div1_q, bdiv1(3'd1));

    // out-of-range index
    run(3'd4, 3'd6, 1'b0, cyc);
    chk(cyc == 1, "R12 done next cycle", 32'(cyc), 32'd1);
    chk(ev_n == 0, "R12 no writes", 32'(ev_n), 32'd0);
    chk(err == 1'b1, "R12 error flag", 32'(err), 32'd1);

    // accepted start clears the flag
    run(3'd1, 3'd1, 1'b0, cyc);
    chk(err == 1'b0, "R11 flag cleared", 32'(err), 32'd0);
    chk(ev_n == 0, "R9 no writes", 32'(ev_n), 32'd0);

    // lock never arrives
    stuck = 1;
    run(3'd1, 3'd0, 1'b0, cyc);
    chk_seq(4'd5, 24'o00065421, "R11 abort");
    chk(err == 1'b1, "R11 timeout flag", 32'(err), 32'd1);
    chk(cyc > TIMEOUT, "R11 wait length", 32'(cyc), 32'(TIMEOUT));
    stuck = 0;

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule